// File: doc/BRIEF.md
# Processor-Side Cache Access Controller

This block sits between a processor port and a cache line directory and decides, one request at a time, what each fetch or store needs. A request that finds its line completes at once: a fetch returns the addressed word, a store writes it into the line. A request that misses holds the processor off with reject, asks for the memory bus, waits for grant, writes a dirty victim back, looks for the page among resident lines to reuse its real page (and reads the map only when none is found), fills the line, then retries the lookup and completes.

Stores depend on two per-line flags reported by the directory. A store to a page whose dirty flag is clear first sends a set-page-dirty command. A store to a shared line also sends the written word to memory as a single-word write. Map-read faults and set-page-dirty faults end the request with an exception. A fetch-and-hold request keeps the bus across requests, so later requests do not wait for grant again. The directory storage and the memory-bus sequencer sit outside the block. Each has a simple handshake: the directory answers lookups combinationally, and a command is held until the sequencer pulses done.

Top module: `cache_access_ctrl`

## Requirements
- R1: A request is accepted when reqValid is high while reject is low. Request codes are: 0 fetch, 1 fetch-and-hold, 2 store, 3 handled as fetch. A fetch that hits returns the word selected by reqWord (2 bits) on rspData with rspValid one cycle after acceptance. Reject is high for exactly that one cycle and the bus is not requested.
- R2: On a miss, reject stays high and busReq is raised. No command is issued until busGrant is seen.
- R3: After grant, if vicDirty is set, the first command is a four-word write-back (cmdOp 0) to vicRpage/vicBlock. vicClean pulses in the cycle its done is seen.
- R4: If a resident line has the same virtual page, its real page is used for the line read and no map read is issued. Otherwise a map read (cmdOp 1) of the virtual page comes first, and the line read uses cmdRdData as the real page.
- R5: The line read is cmdOp 2. After it completes, the lookup is retried and the fetch returns the filled word. Reject then falls, and busReq drops for a request that is not fetch-and-hold.
- R6: A store that hits a non-shared line whose page is dirty writes reqData into the line word (dirWrEn) and completes with no command.
- R7: A store that hits a shared line writes locally and also issues a single-word write (cmdOp 4) carrying the data, word index and real page.
- R8: A store that hits a line whose page-dirty flag is clear issues set-page-dirty (cmdOp 3) before the local write.
- R9: A map-read fault ends the request with excValid and excCode 0, and no line read follows. A set-page-dirty fault ends it with excCode 1, and no local write follows.
- R10: Once granted, fetch-and-hold keeps busReq high after completion. Later requests proceed without grant. The next non-hold request releases the bus when it completes.
- R11: A command stays valid, with an unchanged cmdOp, until cmdDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| reqValid | input | 1 | processor request present |
| reqOp | input | 2 | request code |
| reqVpage | input | PAGE_W | virtual page |
| reqBlock | input | BLK_W | line within page |
| reqWord | input | 2 | word within line |
| reqData | input | DATA_W | store data |
| reject | output | 1 | request in progress, new requests refused |
| rspValid | output | 1 | request complete |
| rspData | output | DATA_W | fetched word |
| excValid | output | 1 | request ended in exception |
| excCode | output | 1 | 0 page fault, 1 write violation |
| lkVpage | output | PAGE_W | lookup virtual page |
| lkBlock | output | BLK_W | lookup line |
| lkWord | output | 2 | lookup/write word |
| lkHit | input | 1 | full match |
| lkShared | input | 1 | matched line is shared |
| lkPageDirty | input | 1 | matched line's page is dirty |
| lkRpage | input | PAGE_W | matched line's real page |
| lkRdData | input | DATA_W | word read from matched line |
| pmHit | input | 1 | some line has the same virtual page |
| pmRpage | input | PAGE_W | real page of that line |
| vicDirty | input | 1 | victim line is dirty |
| vicRpage | input | PAGE_W | victim real page |
| vicBlock | input | BLK_W | victim line |
| vicClean | output | 1 | clear victim dirty flag |
| dirWrEn | output | 1 | write word into matched line |
| dirWrData | output | DATA_W | word to write |
| busReq | output | 1 | memory bus request |
| busGrant | input | 1 | memory bus granted |
| cmdValid | output | 1 | command to sequencer |
| cmdOp | output | 3 | command code |
| cmdPage | output | PAGE_W | command page |
| cmdBlock | output | BLK_W | command line |
| cmdWord | output | 2 | command word |
| cmdData | output | DATA_W | single-word write data |
| cmdDone | input | 1 | command finished, one-cycle pulse |
| cmdFault | input | 1 | fault, valid with cmdDone |
| cmdRdData | input | PAGE_W | real page returned by map read |

## Verification
The assertions assume that cmdDone pulses for one cycle only while a command is valid, and that the directory keeps reporting a hit for a line while the request that found it is still running. The bench models the directory as four entries, which change only on fill, local write or set-page-dirty completion. Its sequencer answers each command on its second valid cycle, so done never overlaps the next command. Fault flags and grant are changed only between requests, apart from the grant-wait case, where grant is raised while the controller waits for it.

// File: rtl/cac_pkg.sv
package cac_pkg;
  localparam int WORD_W = 2;

  typedef enum logic [1:0] {
    OP_FETCH = 2'd0,
    OP_HOLD  = 2'd1,
    OP_STORE = 2'd2,
    OP_RSVD  = 2'd3
  } req_op_e;

  typedef enum logic [2:0] {
    CMD_WRQUAD = 3'd0,
    CMD_RDMAP  = 3'd1,
    CMD_RDQUAD = 3'd2,
    CMD_SETPD  = 3'd3,
    CMD_WRSGL  = 3'd4
  } cmd_op_e;

  typedef struct packed {
    logic    capReq;
    logic    ldRpLk;
    logic    ldRpPm;
    logic    ldRpMap;
    logic    done;
    logic    exc;
    logic    excWv;
    logic    rspHit;
    cmd_op_e op;
  } cac_strobe_t;
endpackage

// File: rtl/cac_ctrl.sv
module cac_ctrl
  import cac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  req_op_e     opQ,
  input  logic        lkHit,
  input  logic        lkShared,
  input  logic        lkPageDirty,
  input  logic        pmHit,
  input  logic        vicDirty,
  input  logic        busGrant,
  input  logic        cmdDone,
  input  logic        cmdFault,
  output logic        reject,
  output logic        busReq,
  output logic        cmdValid,
  output logic        vicClean,
  output logic        dirWrEn,
  output cac_strobe_t stb
);
  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_GRANT, S_WRBK, S_PMAT, S_MAPRD, S_FILL, S_SETPD, S_WSGL
  } state_e;

  state_e state, next;
  logic grantedQ, holding, sharedQ;
  logic owned, isStore, isHold;

  assign owned   = holding | grantedQ;
  assign isStore = (opQ == OP_STORE);
  assign isHold  = (opQ == OP_HOLD);
  assign reject  = (state != S_IDLE);
  assign busReq  = owned | (state == S_GRANT);

  always_comb begin
    next     = state;
    stb      = '0;
    stb.op   = CMD_WRQUAD;
    cmdValid = 1'b0;
    vicClean = 1'b0;
    dirWrEn  = 1'b0;
    case (state)
      S_IDLE: if (reqValid) begin stb.capReq = 1'b1; next = S_LOOK; end
      S_LOOK: begin
        if (isHold && !owned) next = S_GRANT;
        else if (lkHit) begin
          if (!isStore) begin
            stb.done = 1'b1; stb.rspHit = 1'b1; next = S_IDLE;
          end else if ((!lkPageDirty || lkShared) && !owned) begin
            next = S_GRANT;
          end else begin
            stb.ldRpLk = 1'b1;
            if (!lkPageDirty) next = S_SETPD;
            else begin
              dirWrEn = 1'b1;
              if (lkShared) next = S_WSGL;
              else begin stb.done = 1'b1; next = S_IDLE; end
            end
          end
        end
        else if (!owned) next = S_GRANT;
        else if (vicDirty) next = S_WRBK;
        else next = S_PMAT;
      end
      S_GRANT: if (busGrant) next = S_LOOK;
      S_WRBK: begin
        cmdValid = 1'b1; stb.op = CMD_WRQUAD;
        if (cmdDone) begin vicClean = 1'b1; next = S_PMAT; end
      end
      S_PMAT: begin
        if (pmHit) begin stb.ldRpPm = 1'b1; next = S_FILL; end
        else next = S_MAPRD;
      end
      S_MAPRD: begin
        cmdValid = 1'b1; stb.op = CMD_RDMAP;
        if (cmdDone) begin
          if (cmdFault) begin stb.done = 1'b1; stb.exc = 1'b1; next = S_IDLE; end
          else begin stb.ldRpMap = 1'b1; next = S_FILL; end
        end
      end
      S_FILL: begin
        cmdValid = 1'b1; stb.op = CMD_RDQUAD;
        if (cmdDone) next = S_LOOK;
      end
      S_SETPD: begin
        cmdValid = 1'b1; stb.op = CMD_SETPD;
        if (cmdDone) begin
          if (cmdFault) begin
            stb.done = 1'b1; stb.exc = 1'b1; stb.excWv = 1'b1; next = S_IDLE;
          end else begin
            dirWrEn = 1'b1;
            if (sharedQ) next = S_WSGL;
            else begin stb.done = 1'b1; next = S_IDLE; end
          end
        end
      end
      S_WSGL: begin
        cmdValid = 1'b1; stb.op = CMD_WRSGL;
        if (cmdDone) begin stb.done = 1'b1; next = S_IDLE; end
      end
      default: next = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      grantedQ <= 1'b0;
      holding  <= 1'b0;
      sharedQ  <= 1'b0;
    end else begin
      state <= next;
      if (state == S_GRANT && busGrant) begin
        grantedQ <= 1'b1;
        if (isHold) holding <= 1'b1;
      end
      if (stb.ldRpLk) sharedQ <= lkShared;
      if (stb.done) begin
        grantedQ <= 1'b0;
        if (!isHold || stb.exc) holding <= 1'b0;
      end
    end
  end

  // R11: a command is held with the same code until the sequencer answers
  assert_cmd_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdDone |=> cmdValid && (stb.op == $past(stb.op)));
  // R2: no command goes out without the bus being held
  assert_cmd_under_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busReq);
  // R3: victim flag is cleared only when its write-back finishes
  assert_clean_after_wb_R3: assert property (@(posedge clk) disable iff (!rstN)
    vicClean |-> cmdDone && (stb.op == CMD_WRQUAD));
  // R1: reject only rises after an offered request
  assert_accept_on_request_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reject) |-> $past(reqValid));
  // R5: completion releases reject on the next cycle
  assert_release_after_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> !reject);
endmodule

// File: rtl/cac_dpath.sv
module cac_dpath
  import cac_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int BLK_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  cac_strobe_t         stb,
  input  logic [1:0]          reqOp,
  input  logic [PAGE_W-1:0]   reqVpage,
  input  logic [BLK_W-1:0]    reqBlock,
  input  logic [WORD_W-1:0]   reqWord,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [PAGE_W-1:0]   lkRpage,
  input  logic [DATA_W-1:0]   lkRdData,
  input  logic [PAGE_W-1:0]   pmRpage,
  input  logic [PAGE_W-1:0]   vicRpage,
  input  logic [BLK_W-1:0]    vicBlock,
  input  logic [PAGE_W-1:0]   cmdRdData,
  input  logic                dirWrEn,
  input  logic                lkHit,
  output req_op_e             opQ,
  output logic [PAGE_W-1:0]   lkVpage,
  output logic [BLK_W-1:0]    lkBlock,
  output logic [WORD_W-1:0]   lkWord,
  output logic [DATA_W-1:0]   dirWrData,
  output logic [PAGE_W-1:0]   cmdPage,
  output logic [BLK_W-1:0]    cmdBlock,
  output logic [WORD_W-1:0]   cmdWord,
  output logic [DATA_W-1:0]   cmdData,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic                excValid,
  output logic                excCode
);
  logic [PAGE_W-1:0] vpQ, rpQ;
  logic [BLK_W-1:0]  blQ;
  logic [WORD_W-1:0] wordQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ <= OP_FETCH; vpQ <= '0; blQ <= '0; wordQ <= '0; dataQ <= '0; rpQ <= '0;
      rspValid <= 1'b0; rspData <= '0; excValid <= 1'b0; excCode <= 1'b0;
    end else begin
      if (stb.capReq) begin
        opQ <= req_op_e'(reqOp); vpQ <= reqVpage; blQ <= reqBlock;
        wordQ <= reqWord; dataQ <= reqData;
      end
      if (stb.ldRpLk)       rpQ <= lkRpage;
      else if (stb.ldRpPm)  rpQ <= pmRpage;
      else if (stb.ldRpMap) rpQ <= cmdRdData;
      rspValid <= stb.done;
      rspData  <= stb.rspHit ? lkRdData : '0;
      excValid <= stb.exc;
      excCode  <= stb.excWv;
    end
  end

  assign lkVpage   = vpQ;
  assign lkBlock   = blQ;
  assign lkWord    = wordQ;
  assign dirWrData = dataQ;
  assign cmdData   = dataQ;

  always_comb begin
    cmdPage  = rpQ;
    cmdBlock = blQ;
    cmdWord  = wordQ;
    case (stb.op)
      CMD_WRQUAD: begin cmdPage = vicRpage; cmdBlock = vicBlock; cmdWord = '0; end
      CMD_RDMAP:  cmdPage = vpQ;
      default:    ;
    endcase
  end

  // R9: an exception is always reported together with completion
  assert_exc_with_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> rspValid);
  // R6: local writes target a line the directory reports as present
  assert_write_on_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    dirWrEn |-> lkHit);
endmodule

// File: rtl/cache_access_ctrl.sv
module cache_access_ctrl
  import cac_pkg::*;
#(
  parameter int PAGE_W = 20,
  parameter int BLK_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [PAGE_W-1:0] reqVpage,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [1:0]        reqWord,
  input  logic [DATA_W-1:0] reqData,
  output logic              reject,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              excValid,
  output logic              excCode,
  output logic [PAGE_W-1:0] lkVpage,
  output logic [BLK_W-1:0]  lkBlock,
  output logic [1:0]        lkWord,
  input  logic              lkHit,
  input  logic              lkShared,
  input  logic              lkPageDirty,
  input  logic [PAGE_W-1:0] lkRpage,
  input  logic [DATA_W-1:0] lkRdData,
  input  logic              pmHit,
  input  logic [PAGE_W-1:0] pmRpage,
  input  logic              vicDirty,
  input  logic [PAGE_W-1:0] vicRpage,
  input  logic [BLK_W-1:0]  vicBlock,
  output logic              vicClean,
  output logic              dirWrEn,
  output logic [DATA_W-1:0] dirWrData,
  output logic              busReq,
  input  logic              busGrant,
  output logic              cmdValid,
  output logic [2:0]        cmdOp,
  output logic [PAGE_W-1:0] cmdPage,
  output logic [BLK_W-1:0]  cmdBlock,
  output logic [1:0]        cmdWord,
  output logic [DATA_W-1:0] cmdData,
  input  logic              cmdDone,
  input  logic              cmdFault,
  input  logic [PAGE_W-1:0] cmdRdData
);
  cac_strobe_t stb;
  req_op_e     opQ;

  cac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opQ(opQ),
    .lkHit(lkHit), .lkShared(lkShared), .lkPageDirty(lkPageDirty),
    .pmHit(pmHit), .vicDirty(vicDirty), .busGrant(busGrant),
    .cmdDone(cmdDone), .cmdFault(cmdFault), .reject(reject), .busReq(busReq),
    .cmdValid(cmdValid), .vicClean(vicClean), .dirWrEn(dirWrEn), .stb(stb)
  );

  cac_dpath #(.PAGE_W(PAGE_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(reqOp), .reqVpage(reqVpage),
    .reqBlock(reqBlock), .reqWord(reqWord), .reqData(reqData),
    .lkRpage(lkRpage), .lkRdData(lkRdData), .pmRpage(pmRpage),
    .vicRpage(vicRpage), .vicBlock(vicBlock), .cmdRdData(cmdRdData),
    .dirWrEn(dirWrEn), .lkHit(lkHit), .opQ(opQ),
    .lkVpage(lkVpage), .lkBlock(lkBlock), .lkWord(lkWord), .dirWrData(dirWrData),
    .cmdPage(cmdPage), .cmdBlock(cmdBlock), .cmdWord(cmdWord), .cmdData(cmdData),
    .rspValid(rspValid), .rspData(rspData), .excValid(excValid), .excCode(excCode)
  );

  assign cmdOp = stb.op;
endmodule

// File: tb/cache_access_ctrl_test.sv
module cache_access_ctrl_test;
  localparam int PW = 8;
  localparam int BW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, reqValid;
  logic [1:0] reqOp, reqWord;
  logic [PW-1:0] reqVpage;
  logic [BW-1:0] reqBlock;
  logic [DW-1:0] reqData;
  logic reject, rspValid, excValid, excCode;
  logic [DW-1:0] rspData, dirWrData, cmdData, lkRdData;
  logic [PW-1:0] lkVpage, lkRpage, pmRpage, vicRpage, cmdPage, cmdRdData;
  logic [BW-1:0] lkBlock, vicBlock, cmdBlock;
  logic [1:0] lkWord, cmdWord;
  logic lkHit, lkShared, lkPageDirty, pmHit, vicDirty, vicClean, dirWrEn;
  logic busReq, busGrant, cmdValid, cmdDone, cmdFault;
  logic [2:0] cmdOp;

  cache_access_ctrl #(.PAGE_W(PW), .BLK_W(BW), .DATA_W(DW)) uut (.*);

  // directory model: four entries
  logic eVal [4];
  logic [PW-1:0] eVp [4];
  logic [PW-1:0] eRp [4];
  logic [BW-1:0] eBl [4];
  logic eSh [4];
  logic ePd [4];
  logic [DW-1:0] eD [4][4];
  int hitIdx;

  function automatic logic [DW-1:0] fw(int rp, int bl, int w);
    return DW'(16384 + rp * 32 + bl * 4 + w);
  endfunction

  always_comb begin
    lkHit = 1'b0; hitIdx = 0; pmHit = 1'b0; pmRpage = '0;
    for (int e = 3; e >= 0; e--) begin
      if (eVal[e] && eVp[e] == lkVpage) begin
        pmHit = 1'b1; pmRpage = eRp[e];
        if (eBl[e] == lkBlock) begin lkHit = 1'b1; hitIdx = e; end
      end
    end
  end
  assign lkShared    = eSh[hitIdx];
  assign lkPageDirty = ePd[hitIdx];
  assign lkRpage     = eRp[hitIdx];
  assign lkRdData    = eD[hitIdx][lkWord];

  // sequencer model
  logic faultMap, faultSpd;
  int busyCnt, opCnt, stableErr;
  logic [2:0] heldOp;
  int logOp [64];
  int logPage [64];
  int logData [64];
  int logWord [64];
  assign vicRpage  = 8'h77;
  assign vicBlock  = 3'd6;
  assign cmdRdData = cmdPage ^ 8'h5A;
  assign cmdFault  = (cmdOp == 3'd1) ? faultMap : (cmdOp == 3'd3) ? faultSpd : 1'b0;

  always @(posedge clk) begin
    cmdDone <= 1'b0;
    if (cmdValid && !cmdDone) begin
      if (busyCnt == 1) begin
        if (cmdOp != heldOp) stableErr <= stableErr + 1;
        cmdDone <= 1'b1; busyCnt <= 0;
        logOp[opCnt] <= int'(cmdOp); logPage[opCnt] <= int'(cmdPage);
        logData[opCnt] <= int'(cmdData); logWord[opCnt] <= int'(cmdWord);
        opCnt <= opCnt + 1;
        if (cmdOp == 3'd2) begin
          eVal[3] <= 1'b1; eVp[3] <= lkVpage; eBl[3] <= cmdBlock; eRp[3] <= cmdPage;
          eSh[3] <= 1'b0; ePd[3] <= 1'b1;
          for (int w = 0; w < 4; w++) eD[3][w] <= fw(int'(cmdPage), int'(cmdBlock), w);
        end
        if (cmdOp == 3'd3 && !faultSpd) ePd[hitIdx] <= 1'b1;
      end else begin
        busyCnt <= busyCnt + 1; heldOp <= cmdOp;
      end
    end
    if (dirWrEn) eD[hitIdx][lkWord] <= dirWrData;
    if (vicClean) vicDirty <= 1'b0;
  end

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  logic [DW-1:0] rData;
  logic rExc, rCode;
  int rRej, base;
  bit rGap;

  task automatic waitRsp();
    int guard = 0;
    rRej = 0; rGap = 0;
    while (!rspValid && guard < 2000) begin
      if (reject) rRej++; else rGap = 1;
      @(negedge clk); guard++;
    end
    rData = rspData; rExc = excValid; rCode = excCode;
    chk("R5 completion seen, reject low", {31'd0, rspValid, reject}, 2);
  endtask

  task automatic send(input int op, input int vp, input int bl, input int w, input int d);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqVpage = PW'(vp); reqBlock = BW'(bl);
    reqWord = 2'(w); reqData = DW'(d);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doReq(input int op, input int vp, input int bl, input int w, input int d);
    base = opCnt;
    send(op, vp, bl, w, d);
    waitRsp();
  endtask

  task automatic setEntry(input int e, input int vp, input int bl, input int rp,
                          input bit sh, input bit pd);
    eVal[e] = 1'b1; eVp[e] = PW'(vp); eBl[e] = BW'(bl); eRp[e] = PW'(rp);
    eSh[e] = sh; ePd[e] = pd;
    for (int w = 0; w < 4; w++) eD[e][w] = fw(rp, bl, w);
  endtask

  initial begin
    for (int e = 0; e < 4; e++) eVal[e] = 1'b0;
    busyCnt = 0; opCnt = 0; stableErr = 0; heldOp = '0;
    faultMap = 0; faultSpd = 0; vicDirty = 0; busGrant = 1;
    reqValid = 0; reqOp = 0; reqVpage = 0; reqBlock = 0; reqWord = 0; reqData = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset reject", reject, 0);
    chk("R1 reset busReq", busReq, 0);
    chk("R11 reset cmdValid", cmdValid, 0);
    chk("R1 reset rspValid", rspValid, 0);

    setEntry(0, 'h11, 2, 'h21, 0, 1);
    // R1: hit sweep over all words
    for (int w = 0; w < 4; w++) begin
      doReq(0, 'h11, 2, w, 0);
      chk("R1 hit data", rData, fw('h21, 2, w));
      chk("R1 reject cycles", rRej, 1);
      chk("R1 no command", opCnt - base, 0);
      chk("R1 no bus", busReq, 0);
    end
    // reserved code behaves as fetch
    doReq(3, 'h11, 2, 1, 0);
    chk("R1 code 3 as fetch", rData, fw('h21, 2, 1));

    // R4/R5: miss with page match
    doReq(0, 'h11, 5, 1, 0);
    chk("R4 page hit ops", opCnt - base, 1);
    chk("R4 read quad op", logOp[base], 2);
    chk("R4 real page reused", logPage[base], 'h21);
    chk("R5 filled word", rData, fw('h21, 5, 1));
    chk("R5 bus dropped", busReq, 0);
    chk("R5 no gap in reject", rGap, 0);

    // R3/R4: dirty victim, page miss
    vicDirty = 1;
    doReq(0, 'h33, 1, 3, 0);
    chk("R3 op count", opCnt - base, 3);
    chk("R3 write-back first", logOp[base], 0);
    chk("R3 victim page", logPage[base], 'h77);
    chk("R3 victim cleaned", vicDirty, 0);
    chk("R4 map read second", logOp[base+1], 1);
    chk("R4 map of vpage", logPage[base+1], 'h33);
    chk("R4 read quad third", logOp[base+2], 2);
    chk("R4 mapped page used", logPage[base+2], 'h69);
    chk("R5 filled word", rData, fw('h69, 1, 3));

    // R9: map fault
    faultMap = 1;
    doReq(0, 'h44, 0, 0, 0);
    chk("R9 map fault ops", opCnt - base, 1);
    chk("R9 map fault op", logOp[base], 1);
    chk("R9 page fault exc", {rExc, rCode}, 2'b10);
    chk("R9 bus released", busReq, 0);
    faultMap = 0;
    doReq(0, 'h33, 1, 3, 0);
    chk("R9 earlier line intact", rData, fw('h69, 1, 3));

    // R6: store, non-shared, dirty page
    doReq(2, 'h11, 2, 2, 'hBEEF);
    chk("R6 no command", opCnt - base, 0);
    chk("R6 reject cycles", rRej, 1);
    doReq(0, 'h11, 2, 2, 0);
    chk("R6 stored word", rData, 'hBEEF);

    // R7: store to shared line
    setEntry(1, 'h12, 0, 'h22, 1, 1);
    doReq(2, 'h12, 0, 1, 'h1234);
    chk("R7 ops", opCnt - base, 1);
    chk("R7 write single", logOp[base], 4);
    chk("R7 page", logPage[base], 'h22);
    chk("R7 data", logData[base], 'h1234);
    chk("R7 word", logWord[base], 1);
    doReq(0, 'h12, 0, 1, 0);
    chk("R7 local word", rData, 'h1234);

    // R8: store to clean page
    setEntry(2, 'h13, 7, 'h23, 0, 0);
    doReq(2, 'h13, 7, 3, 'h5555);
    chk("R8 ops", opCnt - base, 1);
    chk("R8 set page dirty", logOp[base], 3);
    chk("R8 page", logPage[base], 'h23);
    doReq(0, 'h13, 7, 3, 0);
    chk("R8 local word", rData, 'h5555);
    doReq(2, 'h13, 7, 3, 'h6666);
    chk("R8 dirty page no cmd", opCnt - base, 0);

    // R9: write violation
    ePd[2] = 0; faultSpd = 1;
    doReq(2, 'h13, 7, 0, 'h7777);
    chk("R9 spd ops", opCnt - base, 1);
    chk("R9 write violation exc", {rExc, rCode}, 2'b11);
    faultSpd = 0;
    doReq(0, 'h13, 7, 0, 0);
    chk("R9 no local write", rData, fw('h23, 7, 0));

    // R2: wait for grant
    busGrant = 0;
    base = opCnt;
    send(0, 'h55, 1, 0, 0);
    repeat (5) @(negedge clk);
    chk("R2 reject held", reject, 1);
    chk("R2 bus requested", busReq, 1);
    chk("R2 no command", cmdValid, 0);
    chk("R2 no log", opCnt - base, 0);
    busGrant = 1;
    waitRsp();
    chk("R2 ops after grant", opCnt - base, 2);
    chk("R2 fill data", rData, fw('h0F, 1, 0));

    // R10: fetch-and-hold
    doReq(1, 'h11, 2, 0, 0);
    chk("R10 hold data", rData, fw('h21, 2, 0));
    chk("R10 bus kept", busReq, 1);
    busGrant = 0;
    doReq(1, 'h66, 2, 1, 0);
    chk("R10 ops without grant", opCnt - base, 2);
    chk("R10 fill page", logPage[base+1], 'h3C);
    chk("R10 fill data", rData, fw('h3C, 2, 1));
    chk("R10 still held", busReq, 1);
    doReq(0, 'h11, 2, 0, 0);
    chk("R10 plain releases", busReq, 0);
    busGrant = 1;

    chk("R11 command stable", stableErr, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule